// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block holds the interrupt and fill-level status logic that sits between a pair of transmit/receive FIFOs and a processor. It watches the two fill counts, a receive-overflow pulse and an end-of-transfer pulse. From these it keeps four sticky event bits, masks them with an enable register and drives one interrupt line.

Each direction has its own 8-bit trigger level. "Receive ready" is raised while the receive count is at or above its level. "Transmit request" is raised while the transmit count is at or below its level. Because both are level conditions, clearing them has no lasting effect while the condition still holds.

Software also uses the control register to issue one-cycle flush pulses to either FIFO, and can read both fill counts back. Register writes arrive as a plain strobe with a 2-bit word index and 32 data bits. Reads are combinational from a separate index. No data streams through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `fifo_thr_irq`

## Requirements
- R1: While reset is held, the event register and the enable register read 0, irq and both flush pulses are low, and both trigger levels read DEPTH/4*3.
- R2: The event register is at index 1. Its bit 0 (receive ready) is 1 after any clock edge at which the receive count (zero-extended) was greater than or equal to the receive level.
- R3: Event bit 4 (transmit request) is 1 after any clock edge at which the transmit count was less than or equal to the transmit level.
- R4: A one-cycle rx_overflow pulse sets event bit 8 at the next edge. The bit stays set until software clears it.
- R5: A one-cycle xfer_done pulse sets event bit 12 at the next edge. The bit stays set until software clears it.
- R6: A write to index 1 clears each event bit written as 1 and leaves each bit written as 0. An event arriving at the same edge as its clear wins.
- R7: Bits 0 and 4 are set again at the clearing edge itself while their condition still holds.
- R8: irq is high exactly when some event bit is set whose bit in the enable register (index 0, same layout) is also set. It follows the event register with no added cycle.
- R9: A write to the control register (index 2) with bit 15 set raises rx_fifo_clr for exactly the one cycle after the write edge. Bit 31 does the same for tx_fifo_clr. Both bits read back as 0.
- R10: In the control register, the receive level sits in bits 7:0 and the transmit level in bits 23:16. Both read back as written.
- R11: The count register (index 3) returns the receive count from bit 0 and the transmit count from bit 16. A count reads 0 while its flush pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word index for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Register word index for reads |
| rd_data | output | 32 | Combinational read data |
| rx_count | input | CNT_W | Receive FIFO fill count |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| rx_overflow | input | 1 | Receive overflow pulse |
| xfer_done | input | 1 | Transfer complete pulse |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO flush |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO flush |
| irq | output | 1 | Interrupt request |

## Verification
Each event bit takes exactly one edge to appear: a count, pulse or clear applied before edge N shows in the event register and on irq right after edge N. A flush pulse is high in the single cycle after the write edge, and the count register shows zero during that cycle.

The bench applies every stimulus half a cycle before an edge and reads the result half a cycle after it. The flush checks then look one more cycle later. For the level conditions, it sweeps every level against every count for a 16-entry configuration.

// File: rtl/fthr_pkg.sv
package fthr_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    RG_ENABLE = 2'd0,
    RG_EVENT  = 2'd1,
    RG_CTRL   = 2'd2,
    RG_COUNT  = 2'd3
  } reg_sel_e;

  localparam int N_EVT = 4;
  // event index -> bit position in enable/event words
  localparam int EV_RXRDY = 0;
  localparam int EV_TXREQ = 1;
  localparam int EV_OVF   = 2;
  localparam int EV_DONE  = 3;

  localparam int B_RXCLR  = 15;
  localparam int B_TXCLR  = 31;
  localparam int F_RXLVL  = 0;
  localparam int F_TXLVL  = 16;
  localparam int F_RXCNT  = 0;
  localparam int F_TXCNT  = 16;

  function automatic int evt_pos(int idx);
    return idx * 4;
  endfunction
endpackage

// File: rtl/fthr_level.sv
module fthr_level #(
  parameter int CNT_W       = 7,
  parameter int LVL_W       = 8,
  parameter bit AT_OR_ABOVE = 1'b1
) (
  input  logic [CNT_W-1:0] count,
  input  logic             flush,
  input  logic [LVL_W-1:0] level,
  output logic [CNT_W-1:0] seen,
  output logic             hit
);
  localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

  logic [CMP_W-1:0] c_ext, l_ext;

  always_comb begin
    seen  = flush ? '0 : count;
    c_ext = CMP_W'(seen);
    l_ext = CMP_W'(level);
  end

  generate
    if (AT_OR_ABOVE) begin : g_above
      assign hit = (c_ext >= l_ext);
    end else begin : g_below
      assign hit = (c_ext <= l_ext);
    end
  endgenerate
endmodule

// File: rtl/fthr_events.sv
module fthr_events #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)        pend_o[i] <= 1'b0;
        else if (set_i[i]) pend_o[i] <= 1'b1;
        else if (clr_i[i]) pend_o[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/fthr_cfg.sv
module fthr_cfg
  import fthr_pkg::*;
#(
  parameter int LVL_W   = 8,
  parameter int RST_LVL = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [N_EVT-1:0] enable_o,
  output logic [LVL_W-1:0] rx_lvl_o,
  output logic [LVL_W-1:0] tx_lvl_o,
  output logic             rx_clr_o,
  output logic             tx_clr_o
);
  logic wr_ena, wr_ctl;
  logic [N_EVT-1:0] ena_in;

  assign wr_ena = wr_en && (wr_sel == RG_ENABLE);
  assign wr_ctl = wr_en && (wr_sel == RG_CTRL);

  generate
    for (genvar i = 0; i < N_EVT; i++) begin : g_ena
      assign ena_in[i] = wr_data[evt_pos(i)];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_o <= '0;
      rx_lvl_o <= LVL_W'(RST_LVL);
      tx_lvl_o <= LVL_W'(RST_LVL);
      rx_clr_o <= 1'b0;
      tx_clr_o <= 1'b0;
    end else begin
      if (wr_ena) enable_o <= ena_in;
      if (wr_ctl) begin
        rx_lvl_o <= wr_data[F_RXLVL +: LVL_W];
        tx_lvl_o <= wr_data[F_TXLVL +: LVL_W];
      end
      rx_clr_o <= wr_ctl && wr_data[B_RXCLR];
      tx_clr_o <= wr_ctl && wr_data[B_TXCLR];
    end
  end
endmodule

// File: rtl/fifo_thr_irq.sv
module fifo_thr_irq
  import fthr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_addr,
  output logic [31:0]      rd_data,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             rx_overflow,
  input  logic             xfer_done,
  output logic             rx_fifo_clr,
  output logic             tx_fifo_clr,
  output logic             irq
);
  localparam int RST_LVL = DEPTH / 4 * 3;

  reg_sel_e         wsel, rsel;
  logic [N_EVT-1:0] ena, pend, setv, clrv;
  logic [LVL_W-1:0] rx_lvl, tx_lvl;
  logic [CNT_W-1:0] rx_seen, tx_seen;
  logic             rx_hit, tx_hit;
  logic [31:0]      status_w, enable_w;

  assign wsel = reg_sel_e'(wr_addr);
  assign rsel = reg_sel_e'(rd_addr);

  fthr_cfg #(.LVL_W(LVL_W), .RST_LVL(RST_LVL)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wsel), .wr_data(wr_data),
    .enable_o(ena), .rx_lvl_o(rx_lvl), .tx_lvl_o(tx_lvl),
    .rx_clr_o(rx_fifo_clr), .tx_clr_o(tx_fifo_clr)
  );

  fthr_level #(.CNT_W(CNT_W), .LVL_W(LVL_W), .AT_OR_ABOVE(1'b1)) u_rx_lvl (
    .count(rx_count), .flush(rx_fifo_clr), .level(rx_lvl), .seen(rx_seen), .hit(rx_hit)
  );

  fthr_level #(.CNT_W(CNT_W), .LVL_W(LVL_W), .AT_OR_ABOVE(1'b0)) u_tx_lvl (
    .count(tx_count), .flush(tx_fifo_clr), .level(tx_lvl), .seen(tx_seen), .hit(tx_hit)
  );

  always_comb begin
    setv           = '0;
    setv[EV_RXRDY] = rx_hit;
    setv[EV_TXREQ] = tx_hit;
    setv[EV_OVF]   = rx_overflow;
    setv[EV_DONE]  = xfer_done;
  end

  generate
    for (genvar i = 0; i < N_EVT; i++) begin : g_clr
      assign clrv[i] = wr_en && (wsel == RG_EVENT) && wr_data[evt_pos(i)];
    end
  endgenerate

  fthr_events #(.N(N_EVT)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(setv), .clr_i(clrv), .pend_o(pend)
  );

  always_comb begin
    status_w = '0;
    enable_w = '0;
    for (int i = 0; i < N_EVT; i++) begin
      status_w[evt_pos(i)] = pend[i];
      enable_w[evt_pos(i)] = ena[i];
    end
  end

  assign irq = |(pend & ena);

  always_comb begin
    rd_data = '0;
    unique case (rsel)
      RG_ENABLE: rd_data = enable_w;
      RG_EVENT:  rd_data = status_w;
      RG_CTRL: begin
        rd_data[F_RXLVL +: LVL_W] = rx_lvl;
        rd_data[F_TXLVL +: LVL_W] = tx_lvl;
      end
      RG_COUNT: begin
        rd_data[F_RXCNT +: CNT_W] = rx_seen;
        rd_data[F_TXCNT +: CNT_W] = tx_seen;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/fthr_irq_chk.sv
module fthr_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        rx_overflow,
  input logic        xfer_done,
  input logic        rx_fifo_clr,
  input logic        tx_fifo_clr,
  input logic        irq,
  input logic [31:0] sts,
  input logic [31:0] ena
);
  a_r4_ovf_captured: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |=> sts[8]);

  a_r5_done_captured: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> sts[12]);

  a_r6_ovf_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[8] && !(wr_en && wr_addr == 2'd1 && wr_data[8])) |=> sts[8]);

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ena == 32'd0) |-> !irq);

  a_r8_done_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[12] && ena[12]) |-> irq);

  a_r9_rx_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_clr |-> $past(wr_en && wr_addr == 2'd2 && wr_data[15]));

  a_r9_tx_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_clr |-> $past(wr_en && wr_addr == 2'd2 && wr_data[31]));
endmodule

bind fifo_thr_irq fthr_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rx_overflow(rx_overflow), .xfer_done(xfer_done), .rx_fifo_clr(rx_fifo_clr),
  .tx_fifo_clr(tx_fifo_clr), .irq(irq), .sts(status_w), .ena(enable_w)
);

// File: tb/fifo_thr_irq_test.sv
module fifo_thr_irq_test;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [1:0] A_ENA = 2'd0, A_EVT = 2'd1, A_CTL = 2'd2, A_CNT = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [CNT_W-1:0] rx_count = '0, tx_count = '0;
  logic rx_overflow = 1'b0, xfer_done = 1'b0;
  logic rx_fifo_clr, tx_fifo_clr, irq;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  fifo_thr_irq #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rx_count(rx_count), .tx_count(tx_count),
    .rx_overflow(rx_overflow), .xfer_done(xfer_done), .rx_fifo_clr(rx_fifo_clr),
    .tx_fifo_clr(tx_fifo_clr), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(A_EVT, v); check("R1 event", v, 0);
    rd(A_ENA, v); check("R1 enable", v, 0);
    rd(A_CTL, v); check("R1 levels", v, 32'd12 | (32'd12 << 16));
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 flush", {30'd0, rx_fifo_clr, tx_fifo_clr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2, R7: receive-ready sweep, level 0..17, count 0..16
    wr(A_ENA, 32'h1);
    for (int l = 0; l <= DEPTH + 1; l++) begin
      wr(A_CTL, 32'(l));
      for (int c = 0; c <= DEPTH; c++) begin
        rx_count = CNT_W'(c);
        wr(A_EVT, 32'hFFFF_FFFF);
        rd(A_EVT, v);
        check("R2 rx ready", {31'd0, v[0]}, {31'd0, c >= l});
        check("R8 irq rx", {31'd0, irq}, {31'd0, c >= l});
      end
    end

    // R3: transmit-request sweep
    rx_count = '0;
    wr(A_ENA, 32'h10);
    for (int l = 0; l <= DEPTH + 1; l++) begin
      wr(A_CTL, 32'd31 | (32'(l) << 16));
      for (int c = 0; c <= DEPTH; c++) begin
        tx_count = CNT_W'(c);
        wr(A_EVT, 32'hFFFF_FFFF);
        rd(A_EVT, v);
        check("R3 tx request", {31'd0, v[4]}, {31'd0, c <= l});
        check("R8 irq tx", {31'd0, irq}, {31'd0, c <= l});
      end
    end

    // R10 level readback
    rd(A_CTL, v); check("R10 levels", v, 32'd31 | (32'd17 << 16));
    wr(A_CTL, 32'd9 | (32'd3 << 16));
    rd(A_CTL, v); check("R10 levels", v, 32'd9 | (32'd3 << 16));

    // R7: count 16 >= 9 so bit 0 comes back at its own clear edge
    rx_count = 5'd16; tx_count = 5'd10;
    wr(A_EVT, 32'h1);
    rd(A_EVT, v); check("R7 reassert", {31'd0, v[0]}, 1);
    rx_count = 5'd2;
    wr(A_EVT, 32'h11);
    rd(A_EVT, v); check("R7 released", v, 0);

    // R4 overflow
    rx_overflow = 1'b1; @(negedge clk); rx_overflow = 1'b0;
    rd(A_EVT, v); check("R4 ovf set", v, 32'h100);
    repeat (3) @(negedge clk);
    rd(A_EVT, v); check("R4 ovf sticky", v, 32'h100);
    // R5 done
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    repeat (2) @(negedge clk);
    rd(A_EVT, v); check("R5 done sticky", v, 32'h1100);
    // R8 masking
    wr(A_ENA, 32'h0);
    check("R8 all masked", {31'd0, irq}, 0);
    wr(A_ENA, 32'h1000);
    check("R8 done enabled", {31'd0, irq}, 1);
    rd(A_ENA, v); check("R8 enable readback", v, 32'h1000);
    // R6 write-one-to-clear
    wr(A_EVT, 32'h0);
    rd(A_EVT, v); check("R6 zero write", v, 32'h1100);
    wr(A_EVT, 32'h1000);
    rd(A_EVT, v); check("R6 clear done", v, 32'h100);
    check("R8 irq dropped", {31'd0, irq}, 0);
    rx_overflow = 1'b1;
    wr(A_EVT, 32'h100);
    rx_overflow = 1'b0;
    rd(A_EVT, v); check("R6 set wins", v, 32'h100);
    wr(A_EVT, 32'hFFFF_FFFF);
    rd(A_EVT, v); check("R6 clear all", v, 0);

    // R9, R11 flush pulses and count readback
    rx_count = 5'd5; tx_count = 5'd7;
    rd(A_CNT, v); check("R11 counts", v, 32'd5 | (32'd7 << 16));
    wr(A_CTL, 32'h8000 | 32'd9 | (32'd3 << 16));
    check("R9 rx flush high", {30'd0, rx_fifo_clr, tx_fifo_clr}, 32'h2);
    rd(A_CNT, v); check("R11 rx zero in flush", v, 32'd7 << 16);
    rd(A_CTL, v); check("R9 bit15 reads 0", v, 32'd9 | (32'd3 << 16));
    @(negedge clk);
    check("R9 rx flush one cycle", {30'd0, rx_fifo_clr, tx_fifo_clr}, 0);
    rd(A_CNT, v); check("R11 counts back", v, 32'd5 | (32'd7 << 16));
    wr(A_CTL, 32'h8000_0000 | 32'd9 | (32'd3 << 16));
    check("R9 tx flush high", {30'd0, rx_fifo_clr, tx_fifo_clr}, 32'h1);
    rd(A_CNT, v); check("R11 tx zero in flush", v, 32'd5);
    @(negedge clk);
    check("R9 tx flush one cycle", {30'd0, rx_fifo_clr, tx_fifo_clr}, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule